// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is an up/down timer that turns a free count into centre-aligned pulse-width-modulated outputs. On each enabled tick the counter climbs from zero to a ceiling, turns round, and descends back to zero, so the count traces a symmetric triangle. Each compare channel watches that triangle. The pin changes level where the count crosses the channel's threshold, once on the rising slope and once on the falling slope. The resulting pulse stays centred on the same point of every period, whatever the duty.

The ceiling is taken either from a writable register or from one of three fixed widths (255, 511 or 1023). Threshold values and the register ceiling are written into holding buffers. They take effect only at the turn-round point at the top. A period therefore runs from one top to the next, and a ceiling change can make its two slopes unequal. Two sticky flags report when the count has reached the bottom and, in register-ceiling mode, the top. A host-side strobe clears each flag.

Top module: `dual_slope_pwm`

## Requirements
- R1: While reset is asserted and just after it, `count` is 0 and `pwm_out`, `bot_flag` and `top_flag` are all 0.
- R2: The count changes only on cycles with `tick` high, by one step at a time. It climbs to the effective ceiling, reverses, and descends to 0, where it reverses again. A ceiling of 0 holds the count at 0.
- R3: A tick taken while the count sits at 0 on the descent sets `bot_flag`, which is visible on the following cycle.
- R4: A tick taken at the ceiling on the climb sets `top_flag`, but only when `top_src` is 0 (register ceiling).
- R5: Threshold and ceiling writes land in holding buffers. The value last buffered before a top tick becomes active on that tick, so a write made mid-period leaves the current threshold in force until the next top.
- R6: In output mode 2, a tick at which the count equals the threshold drives the pin low on the climb and high on the descent. The tick at 0 after a descent counts as the climb; the tick at the ceiling counts as the descent.
- R7: Output mode 3 is the mirror image of R6: it drives the pin high on a climbing match and low on a descending match.
- R8: In output modes 0 and 1 the pin is held low.
- R9: A channel whose active threshold exceeds the ceiling never matches, and its pin keeps its level.
- R10: `top_src` values 1, 2 and 3 select fixed ceilings of 255, 511 and 1023. While one of them is selected, a threshold write keeps only the bits below that width.
- R11: A register ceiling written after a top tick governs the climb that follows the next top. The period that starts at that top descends with the old ceiling and climbs with the new one.
- R12: Both flags stay set until their clear strobe. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| top_src | input | 2 | Ceiling source: 0 register, 1/2/3 fixed 255/511/1023 |
| top_we | input | 1 | Write strobe for the ceiling buffer |
| top_wdata | input | CNT_W | Ceiling value to buffer |
| cmp_we | input | NUM_CH | Per-channel threshold write strobe |
| cmp_wdata | input | CNT_W | Threshold value (shared by all channels) |
| mode_we | input | NUM_CH | Per-channel output-mode write strobe |
| mode_wdata | input | 2 | Output mode value |
| bot_clr | input | 1 | Clear strobe for the bottom flag |
| top_clr | input | 1 | Clear strobe for the top flag |
| pwm_out | output | NUM_CH | PWM pins, one per channel |
| bot_flag | output | 1 | Sticky bottom-reached flag |
| top_flag | output | 1 | Sticky top-reached flag |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the block with the defaults, a 16-bit counter and two channels. Two channels let one pin run non-inverted while the other runs inverted over the same triangle, and they let the bench place one threshold above the ceiling while the other still toggles. With a 16-bit count, all three fixed ceilings are reachable, including the 1023 case. A threshold write with bits above the fixed width shows whether masking takes effect. Small register ceilings such as 6 and 3 keep periods to a dozen cycles, so a ceiling change and the asymmetric period it produces can be observed.

// File: rtl/dspwm_pkg.sv
`timescale 1ns/1ps
package dspwm_pkg;

    typedef enum logic [1:0] {
        CEIL_REG  = 2'd0,
        CEIL_W8   = 2'd1,
        CEIL_W9   = 2'd2,
        CEIL_W10  = 2'd3
    } ceil_src_e;

    typedef enum logic [1:0] {
        OMODE_OFF_A  = 2'd0,
        OMODE_OFF_B  = 2'd1,
        OMODE_NONINV = 2'd2,
        OMODE_INV    = 2'd3
    } out_mode_e;

    localparam int FIX_BITS_A = 8;
    localparam int FIX_BITS_B = 9;
    localparam int FIX_BITS_C = 10;

    // Per-tick events from the slope generator
    typedef struct packed {
        logic at_top;   // tick taken at the ceiling on the climb
        logic at_bot;   // tick taken at zero on the descent
        logic climb;    // a match in this state counts as a climbing match
    } slope_ev_t;

endpackage

// File: rtl/pwm_slope_counter.sv
`timescale 1ns/1ps
module pwm_slope_counter
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ceil_src_e        src,
    input  logic             ceil_we,
    input  logic [CNT_W-1:0] ceil_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] ceil_eff,
    output slope_ev_t        ev
);

    localparam logic [CNT_W-1:0] CEIL_A = CNT_W'((1 << FIX_BITS_A) - 1);
    localparam logic [CNT_W-1:0] CEIL_B = CNT_W'((1 << FIX_BITS_B) - 1);
    localparam logic [CNT_W-1:0] CEIL_C = CNT_W'((1 << FIX_BITS_C) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic [CNT_W-1:0] ceil_pend;
        logic [CNT_W-1:0] ceil_live;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit_top, hit_bot;

    always_comb begin
        case (src)
            CEIL_W8:  ceil_eff = CEIL_A;
            CEIL_W9:  ceil_eff = CEIL_B;
            CEIL_W10: ceil_eff = CEIL_C;
            default:  ceil_eff = st_q.ceil_live;
        endcase

        hit_top = st_q.up && (st_q.cnt >= ceil_eff);
        hit_bot = !st_q.up && (st_q.cnt == '0);

        ev.at_top = tick && hit_top;
        ev.at_bot = tick && hit_bot;
        ev.climb  = st_q.up ? (st_q.cnt < ceil_eff) : (st_q.cnt == '0);

        st_d = st_q;
        if (tick) begin
            if (hit_top) begin
                st_d.up        = 1'b0;
                st_d.cnt       = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
                st_d.ceil_live = st_q.ceil_pend;
            end else if (hit_bot) begin
                st_d.up  = 1'b1;
                st_d.cnt = (ceil_eff == '0) ? '0 : CNT_W'(1);
            end else if (st_q.up) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (ceil_we) begin
            st_d.ceil_pend = ceil_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt       <= '0;
            st_q.up        <= 1'b1;
            st_q.ceil_pend <= '0;
            st_q.ceil_live <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/pwm_cmp_channel.sv
`timescale 1ns/1ps
module pwm_cmp_channel
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  slope_ev_t        ev,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    input  logic             mode_we,
    input  logic [1:0]       mode_wdata,
    output logic             pin,
    output logic [1:0]       mode_o
);

    typedef struct packed {
        logic [CNT_W-1:0] thr_pend;
        logic [CNT_W-1:0] thr_live;
        out_mode_e        mode;
        logic             lvl;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   match, drive;

    always_comb begin
        match = tick && (count == st_q.thr_live);
        drive = (st_q.mode == OMODE_NONINV) || (st_q.mode == OMODE_INV);

        st_d = st_q;
        if (match && drive) begin
            if (ev.climb) begin
                st_d.lvl = (st_q.mode == OMODE_INV);
            end else begin
                st_d.lvl = (st_q.mode == OMODE_NONINV);
            end
        end
        if (ev.at_top) begin
            st_d.thr_live = st_q.thr_pend;
        end
        if (thr_we) begin
            st_d.thr_pend = thr_wdata;
        end
        if (mode_we) begin
            st_d.mode = out_mode_e'(mode_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.thr_pend <= '0;
            st_q.thr_live <= '0;
            st_q.mode     <= OMODE_OFF_A;
            st_q.lvl      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin    = st_q.lvl && (st_q.mode == OMODE_NONINV || st_q.mode == OMODE_INV);
    assign mode_o = st_q.mode;

endmodule

// File: rtl/dual_slope_pwm.sv
`timescale 1ns/1ps
module dual_slope_pwm
    import dspwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        top_src,
    input  logic              top_we,
    input  logic [CNT_W-1:0]  top_wdata,
    input  logic [NUM_CH-1:0] cmp_we,
    input  logic [CNT_W-1:0]  cmp_wdata,
    input  logic [NUM_CH-1:0] mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic              bot_clr,
    input  logic              top_clr,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              bot_flag,
    output logic              top_flag,
    output logic [CNT_W-1:0]  count
);

    localparam int MODE_BITS = 2 * NUM_CH;

    typedef struct packed {
        logic bot;
        logic top;
    } flag_st_t;

    ceil_src_e          src;
    slope_ev_t          ev;
    logic [CNT_W-1:0]   ceil_eff;
    logic [CNT_W-1:0]   thr_masked;
    logic [MODE_BITS-1:0] ch_mode;
    flag_st_t           flg_d, flg_q;

    assign src = ceil_src_e'(top_src);

    pwm_slope_counter #(.CNT_W(CNT_W)) u_slope (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .src        (src),
        .ceil_we    (top_we),
        .ceil_wdata (top_wdata),
        .count      (count),
        .ceil_eff   (ceil_eff),
        .ev         (ev)
    );

    // Fixed-width ceilings are all-ones masks of their width
    assign thr_masked = (src == CEIL_REG) ? cmp_wdata : (cmp_wdata & ceil_eff);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_cmp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .count      (count),
            .ev         (ev),
            .thr_we     (cmp_we[g]),
            .thr_wdata  (thr_masked),
            .mode_we    (mode_we[g]),
            .mode_wdata (mode_wdata),
            .pin        (pwm_out[g]),
            .mode_o     (ch_mode[2*g +: 2])
        );
    end

    always_comb begin
        flg_d = flg_q;
        if (bot_clr) flg_d.bot = 1'b0;
        if (top_clr) flg_d.top = 1'b0;
        if (ev.at_bot) flg_d.bot = 1'b1;
        if (ev.at_top && src == CEIL_REG) flg_d.top = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign bot_flag = flg_q.bot;
    assign top_flag = flg_q.top;

endmodule

// File: rtl/dual_slope_pwm_chk.sv
`timescale 1ns/1ps
module dual_slope_pwm_chk #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [1:0]        top_src,
    input logic [CNT_W-1:0]  count,
    input logic              bot_flag,
    input logic              top_flag,
    input logic              bot_clr,
    input logic              top_clr,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [2*NUM_CH-1:0] ch_mode
);

    assert_count_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)
                 || (count == $past(count)));

    assert_bot_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bot_flag) |-> ($past(tick) && $past(count) == '0));

    assert_top_regonly_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_flag) |-> ($past(top_src) == 2'd0));

    assert_fixed_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (top_src == 2'd1 && count <= CNT_W'(255)) |=> (top_src != 2'd1 || count <= CNT_W'(255)));

    assert_bot_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bot_flag && !bot_clr) |=> bot_flag);

    assert_top_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (top_flag && !top_clr) |=> top_flag);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
        assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_mode[2*g+1] |-> !pwm_out[g]);
    end

endmodule

bind dual_slope_pwm dual_slope_pwm_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .top_src  (top_src),
    .count    (count),
    .bot_flag (bot_flag),
    .top_flag (top_flag),
    .bot_clr  (bot_clr),
    .top_clr  (top_clr),
    .pwm_out  (pwm_out),
    .ch_mode  (ch_mode)
);

// File: tb/tb_dual_slope_pwm.sv
`timescale 1ns/1ps
module tb_dual_slope_pwm;

    localparam int CNT_W  = 16;
    localparam int NUM_CH = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tick;
    logic [1:0]        top_src;
    logic              top_we;
    logic [CNT_W-1:0]  top_wdata;
    logic [NUM_CH-1:0] cmp_we;
    logic [CNT_W-1:0]  cmp_wdata;
    logic [NUM_CH-1:0] mode_we;
    logic [1:0]        mode_wdata;
    logic              bot_clr, top_clr;
    logic [NUM_CH-1:0] pwm_out;
    logic              bot_flag, top_flag;
    logic [CNT_W-1:0]  count;

    always #2.5 clk = ~clk;

    dual_slope_pwm #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_src(top_src),
        .top_we(top_we), .top_wdata(top_wdata), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .bot_clr(bot_clr), .top_clr(top_clr), .pwm_out(pwm_out),
        .bot_flag(bot_flag), .top_flag(top_flag), .count(count)
    );

    int total = 0;
    int bad   = 0;
    bit fin   = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_up, m_ceil_pend, m_ceil_live, m_fbot, m_ftop;
    int m_thr_pend[NUM_CH], m_thr_live[NUM_CH], m_mode[NUM_CH], m_lvl[NUM_CH];

    function automatic int ceiling_now();
        case (top_src)
            2'd1:    return 255;
            2'd2:    return 511;
            2'd3:    return 1023;
            default: return m_ceil_live;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  c;
        bit  at_top, at_bot, climbing;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_ceil_pend = 0; m_ceil_live = 0;
            m_fbot = 0; m_ftop = 0;
            for (int i = 0; i < NUM_CH; i++) begin
                m_thr_pend[i] = 0; m_thr_live[i] = 0; m_mode[i] = 0; m_lvl[i] = 0;
            end
        end else begin
            c        = ceiling_now();
            at_top   = (m_up == 1) && (m_cnt >= c);
            at_bot   = (m_up == 0) && (m_cnt == 0);
            climbing = (m_up == 1) ? (m_cnt < c) : (m_cnt == 0);
            if (tick) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (m_cnt == m_thr_live[i] && m_mode[i] >= 2) begin
                        if (climbing) m_lvl[i] = (m_mode[i] == 3) ? 1 : 0;
                        else          m_lvl[i] = (m_mode[i] == 2) ? 1 : 0;
                    end
                end
            end
            if (bot_clr) m_fbot = 0;
            if (top_clr) m_ftop = 0;
            if (tick && at_bot) m_fbot = 1;
            if (tick && at_top && top_src == 2'd0) m_ftop = 1;
            if (tick) begin
                if (at_top) begin
                    m_up = 0;
                    m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                    m_ceil_live = m_ceil_pend;
                    for (int i = 0; i < NUM_CH; i++) m_thr_live[i] = m_thr_pend[i];
                end else if (at_bot) begin
                    m_up = 1;
                    m_cnt = (c == 0) ? 0 : 1;
                end else begin
                    m_cnt = (m_up == 1) ? m_cnt + 1 : m_cnt - 1;
                end
            end
            if (top_we) m_ceil_pend = int'(top_wdata);
            for (int i = 0; i < NUM_CH; i++) begin
                if (cmp_we[i]) m_thr_pend[i] = (top_src == 2'd0) ? int'(cmp_wdata) : (int'(cmp_wdata) & c);
                if (mode_we[i]) m_mode[i] = int'(mode_wdata);
            end
        end
    end

    // Compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(int'(count) == m_cnt, "R2 count", int'(count), m_cnt);
            for (int i = 0; i < NUM_CH; i++) begin
                int exp_pin;
                exp_pin = (m_mode[i] >= 2) ? m_lvl[i] : 0;
                chk(int'(pwm_out[i]) == exp_pin,
                    (m_mode[i] == 2) ? "R6 pin" : ((m_mode[i] == 3) ? "R7 pin" : "R8 pin"),
                    int'(pwm_out[i]), exp_pin);
            end
            chk(int'(bot_flag) == m_fbot, "R3 bot_flag", int'(bot_flag), m_fbot);
            chk(int'(top_flag) == m_ftop, "R4 top_flag", int'(top_flag), m_ftop);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_top(input int v);
        top_we = 1'b1; top_wdata = CNT_W'(v);
        cyc(1);
        top_we = 1'b0;
    endtask

    task automatic wr_cmp(input int ch, input int v);
        cmp_we[ch] = 1'b1; cmp_wdata = CNT_W'(v);
        cyc(1);
        cmp_we = '0;
    endtask

    task automatic wr_mode(input int ch, input int v);
        mode_we[ch] = 1'b1; mode_wdata = 2'(v);
        cyc(1);
        mode_we = '0;
    endtask

    task automatic wait_at(input int c, input int up);
        do cyc(1); while (!(m_cnt == c && m_up == up));
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        if (!fin) begin
            fin = 1;
            chk(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin : main
        int hi0, hi1, first, mx, toggles, prev, prev2, npk, pk0, pk1, pkt0, pkt1;
        rst_n = 1'b0; tick = 1'b0; top_src = 2'd0; top_we = 1'b0; top_wdata = '0;
        cmp_we = '0; cmp_wdata = '0; mode_we = '0; mode_wdata = '0;
        bot_clr = 1'b0; top_clr = 1'b0;
        cyc(3);
        // R1: reset state
        chk(count == '0, "R1 count", int'(count), 0);
        chk(pwm_out == '0, "R1 pwm", int'(pwm_out), 0);
        chk(!bot_flag && !top_flag, "R1 flags", int'({bot_flag, top_flag}), 0);
        rst_n = 1'b1;
        cyc(1);
        chk(count == '0 && !bot_flag && !top_flag, "R1 after release", int'(count), 0);
        tick = 1'b1;

        wr_top(6);
        wr_mode(0, 2);
        wr_mode(1, 3);
        wr_cmp(0, 2);
        wr_cmp(1, 4);
        cyc(40);

        // R6/R7: one full period of 12 ticks starting at the bottom
        wait_at(0, 0);
        hi0 = 0; hi1 = 0;
        for (int i = 0; i < 12; i++) begin
            hi0 += int'(pwm_out[0]);
            hi1 += int'(pwm_out[1]);
            cyc(1);
        end
        chk(hi0 == 4, "R6 high cycles per period", hi0, 4);
        chk(hi1 == 4, "R7 high cycles per period", hi1, 4);

        // R5: threshold write during the climb waits for the next top
        wait_at(1, 1);
        cmp_we[0] = 1'b1; cmp_wdata = CNT_W'(5);
        cyc(1);
        cmp_we = '0;
        wait_at(3, 1);
        chk(pwm_out[0] == 1'b0, "R5 old threshold still live", int'(pwm_out[0]), 0);
        wait_at(3, 1);
        chk(pwm_out[0] == 1'b1, "R5 new threshold after top", int'(pwm_out[0]), 1);

        // R9: threshold above the ceiling holds the pin
        wr_cmp(1, 9);
        cyc(20);
        first = int'(pwm_out[1]);
        for (int i = 0; i < 30; i++) begin
            cyc(1);
            chk(int'(pwm_out[1]) == first, "R9 pin holds", int'(pwm_out[1]), first);
        end

        // R11: ceiling change gives an asymmetric period
        wait_at(5, 0);
        wr_top(3);
        npk = 0; pk0 = -1; pk1 = -1; pkt0 = 0; pkt1 = 0;
        prev2 = int'(count); cyc(1); prev = int'(count);
        for (int i = 0; i < 40; i++) begin
            cyc(1);
            if (prev > prev2 && int'(count) < prev) begin
                if (npk == 0) begin pk0 = prev; pkt0 = i; end
                else if (npk == 1) begin pk1 = prev; pkt1 = i; end
                npk++;
            end
            prev2 = prev; prev = int'(count);
        end
        chk(pk0 == 6, "R11 first peak old ceiling", pk0, 6);
        chk(pk1 == 3, "R11 second peak new ceiling", pk1, 3);
        chk(pkt1 - pkt0 == 9, "R11 descend 6 plus climb 3", pkt1 - pkt0, 9);

        // R8: modes 0 and 1 hold the pin low
        wr_cmp(0, 1);
        cyc(12);
        wr_mode(0, 0);
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            chk(pwm_out[0] == 1'b0, "R8 mode0 low", int'(pwm_out[0]), 0);
        end
        wr_mode(0, 1);
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            chk(pwm_out[0] == 1'b0, "R8 mode1 low", int'(pwm_out[0]), 0);
        end
        wr_mode(0, 2);
        cyc(10);

        // R3: flag set on the tick taken at zero on the descent
        wait_at(1, 0);
        bot_clr = 1'b1;
        cyc(1);
        bot_clr = 1'b0;
        chk(bot_flag == 1'b0, "R3 not yet set at zero", int'(bot_flag), 0);
        cyc(1);
        chk(bot_flag == 1'b1, "R3 set after bottom tick", int'(bot_flag), 1);

        // R12: set beats clear; plain clear works
        wait_at(0, 0);
        bot_clr = 1'b1;
        cyc(1);
        bot_clr = 1'b0;
        chk(bot_flag == 1'b1, "R12 set wins over clear", int'(bot_flag), 1);
        bot_clr = 1'b1;
        cyc(1);
        bot_clr = 1'b0;
        chk(bot_flag == 1'b0, "R12 clear alone", int'(bot_flag), 0);
        wait_at(3, 1);
        top_clr = 1'b1;
        cyc(1);
        top_clr = 1'b0;
        chk(top_flag == 1'b1, "R12 top set wins over clear", int'(top_flag), 1);
        cyc(2);
        chk(top_flag == 1'b1, "R12 top flag sticky", int'(top_flag), 1);

        // R4 and R10: fixed 8-bit ceiling, masked threshold
        top_src = 2'd1;
        top_clr = 1'b1;
        cyc(1);
        top_clr = 1'b0;
        wr_cmp(0, 'h1280);
        mx = 0; toggles = 0; prev = int'(pwm_out[0]);
        for (int i = 0; i < 1100; i++) begin
            cyc(1);
            if (int'(count) > mx) mx = int'(count);
            if (int'(pwm_out[0]) != prev) toggles++;
            prev = int'(pwm_out[0]);
        end
        chk(mx == 255, "R10 fixed ceiling 255", mx, 255);
        chk(toggles >= 2, "R10 masked threshold matches", toggles, 2);
        chk(top_flag == 1'b0, "R4 no top flag in fixed mode", int'(top_flag), 0);

        top_src = 2'd3;
        mx = 0;
        for (int i = 0; i < 2300; i++) begin
            cyc(1);
            if (int'(count) > mx) mx = int'(count);
        end
        chk(mx == 1023, "R10 fixed ceiling 1023", mx, 1023);

        top_src = 2'd2;
        wait_at(0, 0);
        mx = 0;
        for (int i = 0; i < 1100; i++) begin
            cyc(1);
            if (int'(count) > mx) mx = int'(count);
        end
        chk(mx == 511, "R10 fixed ceiling 511", mx, 511);

        // R2: gated ticks, back on register ceiling
        top_src = 2'd0;
        for (int i = 0; i < 300; i++) begin
            tick = (i % 3 != 0);
            cyc(1);
        end
        tick = 1'b0;
        cyc(1);
        prev = int'(count);
        cyc(5);
        chk(int'(count) == prev, "R2 count frozen without tick", int'(count), prev);
        tick = 1'b1;
        cyc(20);

        fin = 1;
        summary();
        $finish;
    end

endmodule